// File: doc/BRIEF.md
# Paged Program Counter Next-Address Unit

This unit holds a 15-bit program counter and computes the value it takes next. Each step that is enabled applies one control-transfer kind. The PC can advance by the instruction length, take a full 15-bit target, or take a target that keeps only the upper PC bits. It can also move by a small signed displacement, jump through the accumulator, take a byte fetched from a table, or take a return address. The decoder, the return stack and the program memory sit outside the unit, and their results arrive as inputs.

Two of the target forms keep part of the current PC. A jump within a page keeps the top 3 bits. Accumulator-based forms keep the top 7 bits. A relative jump uses a full-width 15-bit sum, so it may cross any page boundary. The unit also gives a table-fetch address on every cycle, made from the upper PC bits and the accumulator, so that the program memory can be read for table loads.

Top module: `pcnx_unit`

## Requirements
- R1: While `rst_n` is low, the PC is 0.
- R2: When `adv` is low, the PC holds its value whatever the other inputs are.
- R3: For kind 0 (sequential), the next PC is PC + `ilen`, taken modulo 2^15.
- R4: For kind 1 (long), the next PC is `imm[14:0]`.
- R5: For kind 2 (in-page), the next PC is {PC[14:12], `imm[11:0]`}. Bits 14:12 of `imm` are ignored.
- R6: For kind 3 (relative), `imm[5:0]` is a two's-complement offset from -32 to +31. The next PC is PC + offset, taken modulo 2^15, with no page limit.
- R7: For kind 3 with `imm[5:0]` = 0, `rel_illegal` is 1 and the next PC is PC + `ilen`. `rel_illegal` is 0 in every other case.
- R8: For kind 4 (accumulator jump), the next PC is {PC[14:8], `acc`}.
- R9: `tbl_addr` always equals {PC[14:8], `acc`}.
- R10: For kind 5 (table byte to PC), the next PC is {PC[14:8], `tbl_byte`}.
- R11: For kind 6 (return), the next PC is `ret_addr`.
- R12: Kind 7 behaves like kind 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| adv | input | 1 | Step enable |
| kind | input | 3 | Control-transfer kind |
| ilen | input | 2 | Instruction length in bytes |
| imm | input | 15 | Immediate field from the decoder |
| acc | input | 8 | Accumulator value |
| tbl_byte | input | 8 | Byte fetched by a table read |
| ret_addr | input | 15 | Address popped from the return stack |
| pc | output | 15 | Registered program counter |
| next_pc | output | 15 | Value the PC takes at the next enabled edge |
| tbl_addr | output | 15 | Table-fetch address |
| rel_illegal | output | 1 | Relative jump with a zero offset |

## Verification
The assertions run on every cycle and check these behaviours:
- the PC holds when `adv` is low;
- the sequential and long targets;
- the preserved page bits of an in-page jump;
- the table-address composition;
- the exact condition for the zero-offset flag.

Some behaviours only the bench scenarios can show:
- relative jumps that cross page boundaries and wrap;
- targets composed from the accumulator and the table byte;
- return addresses;
- the spare kind code.

The bench also shows reset taking effect in the middle of a run.

// File: rtl/pcnx_pkg.sv
package pcnx_pkg;
    localparam int PCNX_PC_W   = 15;
    localparam int PCNX_PAGE_W = 12;
    localparam int PCNX_BYTE_W = 8;
    localparam int PCNX_REL_W  = 6;
    localparam int PCNX_KIND_W = 3;
    localparam int PCNX_LEN_W  = 2;

    typedef enum logic [PCNX_KIND_W-1:0] {
        XF_SEQ   = 3'd0,
        XF_LONG  = 3'd1,
        XF_PAGE  = 3'd2,
        XF_REL   = 3'd3,
        XF_ACCJ  = 3'd4,
        XF_TBLPC = 3'd5,
        XF_RET   = 3'd6,
        XF_SPARE = 3'd7
    } xfer_e;
endpackage

// File: rtl/pcnx_step_add.sv
module pcnx_step_add #(
    parameter int PC_W  = 15,
    parameter int LEN_W = 2
) (
    input  logic [PC_W-1:0]  base,
    input  logic [LEN_W-1:0] len,
    output logic [PC_W-1:0]  sum
);
    localparam int PAD_W = PC_W - LEN_W;

    always_comb begin
        sum = base + {{PAD_W{1'b0}}, len};
    end
endmodule

// File: rtl/pcnx_rel_add.sv
module pcnx_rel_add #(
    parameter int PC_W  = 15,
    parameter int REL_W = 6
) (
    input  logic [PC_W-1:0]  base,
    input  logic [REL_W-1:0] off,
    output logic [PC_W-1:0]  tgt,
    output logic             is_zero
);
    localparam int EXT_W = PC_W - REL_W;

    logic [PC_W-1:0] off_ext;

    always_comb begin
        off_ext = {{EXT_W{off[REL_W-1]}}, off};
        tgt     = base + off_ext;
        is_zero = (off == '0);
    end
endmodule

// File: rtl/pcnx_page_join.sv
module pcnx_page_join #(
    parameter int PC_W  = 15,
    parameter int LOW_W = 8
) (
    input  logic [PC_W-1:0]  base,
    input  logic [LOW_W-1:0] low,
    output logic [PC_W-1:0]  joined
);
    generate
        if (LOW_W >= PC_W) begin : g_full
            assign joined = low[PC_W-1:0];
        end else begin : g_keep
            assign joined = {base[PC_W-1:LOW_W], low};
        end
    endgenerate
endmodule

// File: rtl/pcnx_unit.sv
module pcnx_unit
    import pcnx_pkg::*;
#(
    parameter int PC_W   = PCNX_PC_W,
    parameter int PAGE_W = PCNX_PAGE_W,
    parameter int BYTE_W = PCNX_BYTE_W,
    parameter int REL_W  = PCNX_REL_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   adv,
    input  logic [PCNX_KIND_W-1:0] kind,
    input  logic [PCNX_LEN_W-1:0]  ilen,
    input  logic [PC_W-1:0]        imm,
    input  logic [BYTE_W-1:0]      acc,
    input  logic [BYTE_W-1:0]      tbl_byte,
    input  logic [PC_W-1:0]        ret_addr,
    output logic [PC_W-1:0]        pc,
    output logic [PC_W-1:0]        next_pc,
    output logic [PC_W-1:0]        tbl_addr,
    output logic                   rel_illegal
);
    typedef struct packed {
        logic [PC_W-1:0] pc;
        logic            ill;
    } pc_state_t;

    pc_state_t st_d, st_q;

    logic [PC_W-1:0] seq_tgt, rel_tgt, page_tgt, accj_tgt, tblpc_tgt, tbla_tgt;
    logic            rel_zero;
    xfer_e           kind_e;

    assign kind_e = xfer_e'(kind);

    pcnx_step_add #(.PC_W(PC_W), .LEN_W(PCNX_LEN_W)) u_step (
        .base(st_q.pc), .len(ilen), .sum(seq_tgt)
    );

    pcnx_rel_add #(.PC_W(PC_W), .REL_W(REL_W)) u_rel (
        .base(st_q.pc), .off(imm[REL_W-1:0]), .tgt(rel_tgt), .is_zero(rel_zero)
    );

    pcnx_page_join #(.PC_W(PC_W), .LOW_W(PAGE_W)) u_page (
        .base(st_q.pc), .low(imm[PAGE_W-1:0]), .joined(page_tgt)
    );

    pcnx_page_join #(.PC_W(PC_W), .LOW_W(BYTE_W)) u_accj (
        .base(st_q.pc), .low(acc), .joined(accj_tgt)
    );

    pcnx_page_join #(.PC_W(PC_W), .LOW_W(BYTE_W)) u_tblpc (
        .base(st_q.pc), .low(tbl_byte), .joined(tblpc_tgt)
    );

    pcnx_page_join #(.PC_W(PC_W), .LOW_W(BYTE_W)) u_tbla (
        .base(st_q.pc), .low(acc), .joined(tbla_tgt)
    );

    always_comb begin
        st_d.ill = 1'b0;
        unique case (kind_e)
            XF_LONG:  st_d.pc = imm;
            XF_PAGE:  st_d.pc = page_tgt;
            XF_REL: begin
                if (rel_zero) begin
                    st_d.pc  = seq_tgt;
                    st_d.ill = 1'b1;
                end else begin
                    st_d.pc = rel_tgt;
                end
            end
            XF_ACCJ:  st_d.pc = accj_tgt;
            XF_TBLPC: st_d.pc = tblpc_tgt;
            XF_RET:   st_d.pc = ret_addr;
            default:  st_d.pc = seq_tgt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else if (adv) begin
            st_q <= st_d;
        end
    end

    assign pc          = st_q.pc;
    assign next_pc     = st_d.pc;
    assign tbl_addr    = tbla_tgt;
    assign rel_illegal = st_d.ill;
endmodule

// File: rtl/pcnx_chk.sv
module pcnx_chk #(
    parameter int PC_W   = 15,
    parameter int PAGE_W = 12,
    parameter int BYTE_W = 8,
    parameter int REL_W  = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              adv,
    input logic [2:0]        kind,
    input logic [1:0]        ilen,
    input logic [PC_W-1:0]   imm,
    input logic [BYTE_W-1:0] acc,
    input logic [PC_W-1:0]   pc,
    input logic [PC_W-1:0]   tbl_addr,
    input logic              rel_illegal
);
    localparam int HI_PAGE = PC_W - PAGE_W;

    // R1
    reset_zero_chk: assert property (@(posedge clk) !rst_n |=> (!rst_n -> pc == '0));

    // R2
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(pc));

    // R3
    seq_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && kind == 3'd0) |=> pc == PC_W'($past(pc) + {{(PC_W-2){1'b0}}, $past(ilen)}));

    // R4
    long_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && kind == 3'd1) |=> pc == $past(imm));

    // R5
    page_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && kind == 3'd2) |=> pc[PC_W-1 -: HI_PAGE] == $past(pc[PC_W-1 -: HI_PAGE]));

    // R7
    illegal_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rel_illegal == (kind == 3'd3 && imm[REL_W-1:0] == '0));

    // R9
    tbl_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tbl_addr == {pc[PC_W-1:BYTE_W], acc});
endmodule

bind pcnx_unit pcnx_chk #(
    .PC_W(PC_W), .PAGE_W(PAGE_W), .BYTE_W(BYTE_W), .REL_W(REL_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .adv(adv), .kind(kind), .ilen(ilen),
    .imm(imm), .acc(acc), .pc(pc), .tbl_addr(tbl_addr),
    .rel_illegal(rel_illegal)
);

// File: tb/pcnx_unit_test.sv
module pcnx_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        adv = 1'b0;
    logic [2:0]  kind = '0;
    logic [1:0]  ilen = '0;
    logic [14:0] imm = '0;
    logic [7:0]  acc = '0;
    logic [7:0]  tbl_byte = '0;
    logic [14:0] ret_addr = '0;
    logic [14:0] pc, next_pc, tbl_addr;
    logic        rel_illegal;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    pcnx_unit uut (
        .clk(clk), .rst_n(rst_n), .adv(adv), .kind(kind), .ilen(ilen),
        .imm(imm), .acc(acc), .tbl_byte(tbl_byte), .ret_addr(ret_addr),
        .pc(pc), .next_pc(next_pc), .tbl_addr(tbl_addr),
        .rel_illegal(rel_illegal)
    );

    typedef struct packed {
        logic [2:0]  k;
        logic [1:0]  len;
        logic [14:0] im;
        logic [7:0]  ac;
        logic [7:0]  tb;
        logic [14:0] ra;
        logic [14:0] exp;
        logic        ill;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VECS [NV] = '{
        '{3'd1, 2'd1, 15'h7FFE, 8'h00, 8'h00, 15'h0000, 15'h7FFE, 1'b0},
        '{3'd0, 2'd3, 15'h0000, 8'h11, 8'h00, 15'h0000, 15'h0001, 1'b0},
        '{3'd1, 2'd2, 15'h0FFF, 8'h00, 8'h00, 15'h0000, 15'h0FFF, 1'b0},
        '{3'd0, 2'd1, 15'h0000, 8'h22, 8'h00, 15'h0000, 15'h1000, 1'b0},
        '{3'd2, 2'd2, 15'h7ABC, 8'h00, 8'h00, 15'h0000, 15'h1ABC, 1'b0},
        '{3'd3, 2'd1, 15'h001F, 8'h00, 8'h00, 15'h0000, 15'h1ADB, 1'b0},
        '{3'd1, 2'd3, 15'h2FF0, 8'h00, 8'h00, 15'h0000, 15'h2FF0, 1'b0},
        '{3'd3, 2'd1, 15'h001F, 8'h00, 8'h00, 15'h0000, 15'h300F, 1'b0},
        '{3'd3, 2'd1, 15'h0020, 8'h00, 8'h00, 15'h0000, 15'h2FEF, 1'b0},
        '{3'd3, 2'd1, 15'h7FC0, 8'h00, 8'h00, 15'h0000, 15'h2FF0, 1'b1},
        '{3'd4, 2'd1, 15'h0000, 8'h5A, 8'h00, 15'h0000, 15'h2F5A, 1'b0},
        '{3'd5, 2'd1, 15'h0000, 8'h77, 8'hC3, 15'h0000, 15'h2FC3, 1'b0},
        '{3'd6, 2'd1, 15'h0000, 8'h00, 8'h00, 15'h4321, 15'h4321, 1'b0},
        '{3'd7, 2'd2, 15'h0000, 8'h00, 8'h00, 15'h1111, 15'h4323, 1'b0},
        '{3'd3, 2'd1, 15'h003F, 8'h00, 8'h00, 15'h0000, 15'h4322, 1'b0},
        '{3'd1, 2'd1, 15'h0000, 8'h00, 8'h00, 15'h0000, 15'h0000, 1'b0},
        '{3'd3, 2'd1, 15'h003F, 8'h00, 8'h00, 15'h0000, 15'h7FFF, 1'b0}
    };

    function automatic string tag_of(input logic [2:0] k, input logic il);
        if (il) return "R7";
        case (k)
            3'd0: return "R3";
            3'd1: return "R4";
            3'd2: return "R5";
            3'd3: return "R6";
            3'd4: return "R8";
            3'd5: return "R10";
            3'd6: return "R11";
            default: return "R12";
        endcase
    endfunction

    task automatic check(input string req, input logic [14:0] act, input logic [14:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [14:0] prev;
        repeat (2) @(posedge clk);
        #1;
        check("R1", pc, 15'h0000);
        @(negedge clk);
        rst_n = 1'b1;

        prev = 15'h0000;
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            adv = 1'b1;
            kind = VECS[i].k;
            ilen = VECS[i].len;
            imm = VECS[i].im;
            acc = VECS[i].ac;
            tbl_byte = VECS[i].tb;
            ret_addr = VECS[i].ra;
            #1;
            check("R7", {14'd0, rel_illegal}, {14'd0, VECS[i].ill});
            check("R9", tbl_addr, {prev[14:8], VECS[i].ac});
            @(posedge clk);
            #1;
            check(tag_of(VECS[i].k, VECS[i].ill), pc, VECS[i].exp);
            prev = VECS[i].exp;
        end

        // R2: disabled step with a long-jump request keeps PC
        @(negedge clk);
        adv = 1'b0;
        kind = 3'd1;
        imm = 15'h1234;
        repeat (3) @(posedge clk);
        #1;
        check("R2", pc, 15'h7FFF);

        // R3: wrap from top by one
        @(negedge clk);
        adv = 1'b1;
        kind = 3'd0;
        ilen = 2'd1;
        @(posedge clk);
        #1;
        check("R3", pc, 15'h0000);

        // R8: accumulator jump at the top page
        @(negedge clk);
        kind = 3'd1;
        imm = 15'h7F00;
        @(posedge clk);
        @(negedge clk);
        kind = 3'd4;
        acc = 8'hFF;
        @(posedge clk);
        #1;
        check("R8", pc, 15'h7FFF);

        // R1: reset in the middle of a run
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check("R1", pc, 15'h0000);
        @(negedge clk);
        rst_n = 1'b1;
        adv = 1'b0;

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule